// File: doc/BRIEF.md
# Legacy PC Control Port Decoder

This block sits on a PC-style I/O bus and decodes a small fixed set of legacy control and debug ports. Each bus access is a single-cycle write strobe or read strobe with a 16-bit port address and up to 16 bits of data. The block drives the A20 gate level and latches the FPU-error interrupt. It also raises a one-cycle power-off request, once a fixed eight-character ASCII key has been written byte by byte to one port. Firmware panic writes and debug character writes are turned into one-cycle strobes that carry the written value.

The power-off guard is a small state machine with eight states, `S_IDX0` to `S_IDX7`. The state counts how many key characters have matched in order: "S", "h", "u", "t", "d", "o", "w", "n". A write to the key port in state `S_IDX<k>` has three possible transitions. `ADVANCE` moves to `S_IDX<k+1>` when the low byte equals character k. `FIRE` returns to `S_IDX0` and requests power-off when the state is `S_IDX7` and the byte is "n". `MISMATCH` returns to `S_IDX0` on any other byte, and that byte is not matched again. Writes to other ports leave the state alone.

Registered outputs change on the clock edge that samples the strobe. The read data is combinational from the address and the read strobe.

Top module: `sysctl_port_decoder`

## Requirements
- R1: A write to port 0x0092 sets `a20_en` to data bit 1 from the next cycle on. Data bit 0 (fast reset) has no effect on any output.
- R2: While `rd_stb` is high, `rdata` is `{14'b0, a20_en, 1'b0}` for port 0x0092 and zero for every other port. It is zero when no read is strobed.
- R3: Writes to port 0x0080 and to undecoded ports change no output.
- R4: A high `fpu_err_evt` sets `fpu_irq` from the next cycle. The request stays high until a write to port 0x00F0 with any data lowers it in the following cycle.
- R5: When `fpu_err_evt` and a write to port 0x00F0 fall in the same cycle, `fpu_irq` is high in the next cycle.
- R6: On port 0x8900, a low byte that equals the next expected key character advances the match state. Any other byte returns it to `S_IDX0`. Writes to other ports do not touch it.
- R7: When the eighth key character ("n", 0x6E) matches, `shutdown_req` is high for exactly one cycle and matching restarts from `S_IDX0`.
- R8: A write to port 0x0400 or 0x0401 pulses `fw_panic` for one cycle, with the 16-bit data in `panic_line`. A newer panic write overwrites `panic_line`.
- R9: A write to port 0x0501 or 0x0502 pulses `vid_panic` for one cycle, with the 16-bit data in `panic_line`.
- R10: A write to port 0x0402, 0x0403, 0x0500 or 0x0503 pulses `char_vld` for one cycle, with the low data byte in `char_data`.
- R11: A synchronous reset sets `a20_en` and `fpu_irq` low, clears every pulse output and returns the match state to `S_IDX0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| addr | input | 16 | Port address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| fpu_err_evt | input | 1 | FPU error event |
| a20_en | output | 1 | A20 gate enable level |
| fpu_irq | output | 1 | Latched FPU error interrupt request (ISA line 13) |
| shutdown_req | output | 1 | One-cycle power-off request |
| fw_panic | output | 1 | One-cycle system firmware panic strobe |
| vid_panic | output | 1 | One-cycle video firmware panic strobe |
| panic_line | output | 16 | Value carried by the latest panic write |
| char_vld | output | 1 | One-cycle debug character strobe |
| char_data | output | 8 | Debug character byte |

## Verification
Two functions can fall in the same cycle: the FPU-error event setting the interrupt, and a write to the clear port lowering it. The bench drives both in one cycle and expects the request to be high afterwards. It then clears the request with a write on its own to confirm that the clear still works. The key matcher is also exercised with foreign port writes between its bytes, and with a doubled first character that has to break the match.

// File: rtl/sysctl_port_pkg.sv
package sysctl_port_pkg;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] P_POST    = 16'h0080;
    localparam logic [ADDR_W-1:0] P_A20     = 16'h0092;
    localparam logic [ADDR_W-1:0] P_FPUCLR  = 16'h00F0;
    localparam logic [ADDR_W-1:0] P_FWPAN0  = 16'h0400;
    localparam logic [ADDR_W-1:0] P_FWPAN1  = 16'h0401;
    localparam logic [ADDR_W-1:0] P_FWCHR0  = 16'h0402;
    localparam logic [ADDR_W-1:0] P_FWCHR1  = 16'h0403;
    localparam logic [ADDR_W-1:0] P_VIDCHR0 = 16'h0500;
    localparam logic [ADDR_W-1:0] P_VIDPAN0 = 16'h0501;
    localparam logic [ADDR_W-1:0] P_VIDPAN1 = 16'h0502;
    localparam logic [ADDR_W-1:0] P_VIDCHR1 = 16'h0503;
    localparam logic [ADDR_W-1:0] P_KEY     = 16'h8900;

    localparam int KEY_LEN = 8;
    localparam logic [8*KEY_LEN-1:0] KEY_STR = "Shutdown";

    typedef enum logic [2:0] {
        S_IDX0, S_IDX1, S_IDX2, S_IDX3, S_IDX4, S_IDX5, S_IDX6, S_IDX7
    } key_st_t;

    typedef struct packed {
        logic a20;
        logic fpuclr;
        logic fwpanic;
        logic vidpanic;
        logic chr;
        logic key;
    } port_hit_t;
endpackage

// File: rtl/sysctl_port_decode.sv
module sysctl_port_decode
    import sysctl_port_pkg::*;
(
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    output port_hit_t         hit
);
    always_comb begin
        hit          = '0;
        hit.a20      = wr_stb && (addr == P_A20);
        hit.fpuclr   = wr_stb && (addr == P_FPUCLR);
        hit.fwpanic  = wr_stb && (addr == P_FWPAN0 || addr == P_FWPAN1);
        hit.vidpanic = wr_stb && (addr == P_VIDPAN0 || addr == P_VIDPAN1);
        hit.chr      = wr_stb && (addr == P_FWCHR0 || addr == P_FWCHR1 ||
                                  addr == P_VIDCHR0 || addr == P_VIDCHR1);
        hit.key      = wr_stb && (addr == P_KEY);
    end
endmodule

// File: rtl/sysctl_key_matcher.sv
module sysctl_key_matcher
    import sysctl_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       fire
);
    key_st_t    st, st_nxt;
    logic       fire_nxt;
    logic [7:0] expect_byte;

    always_comb begin
        expect_byte = KEY_STR[(KEY_LEN-1-int'(st))*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDX0;
        else     st <= st_nxt;
    end

    always_comb begin
        st_nxt   = st;
        fire_nxt = 1'b0;
        if (key_wr) begin
            unique case (st)
                S_IDX7: begin
                    st_nxt   = S_IDX0;
                    fire_nxt = (key_byte == expect_byte);
                end
                default: begin
                    st_nxt = (key_byte == expect_byte) ? key_st_t'(st + 3'd1) : S_IDX0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fire <= 1'b0;
        else     fire <= fire_nxt;
    end
endmodule

// File: rtl/sysctl_event_regs.sv
module sysctl_event_regs
    import sysctl_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  port_hit_t         hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fpu_err_evt,
    output logic              a20_en,
    output logic              fpu_irq,
    output logic              fw_panic,
    output logic              vid_panic,
    output logic [DATA_W-1:0] panic_line,
    output logic              char_vld,
    output logic [7:0]        char_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            a20_en     <= 1'b0;
            fpu_irq    <= 1'b0;
            fw_panic   <= 1'b0;
            vid_panic  <= 1'b0;
            char_vld   <= 1'b0;
            panic_line <= '0;
            char_data  <= '0;
        end else begin
            if (hit.a20) a20_en <= wdata[1];
            if (fpu_err_evt)     fpu_irq <= 1'b1;
            else if (hit.fpuclr) fpu_irq <= 1'b0;
            fw_panic  <= hit.fwpanic;
            vid_panic <= hit.vidpanic;
            char_vld  <= hit.chr;
            if (hit.fwpanic || hit.vidpanic) panic_line <= wdata;
            if (hit.chr) char_data <= wdata[7:0];
        end
    end
endmodule

// File: rtl/sysctl_port_decoder.sv
module sysctl_port_decoder
    import sysctl_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [15:0]       addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              fpu_err_evt,
    output logic              a20_en,
    output logic              fpu_irq,
    output logic              shutdown_req,
    output logic              fw_panic,
    output logic              vid_panic,
    output logic [DATA_W-1:0] panic_line,
    output logic              char_vld,
    output logic [7:0]        char_data
);
    port_hit_t hit;

    sysctl_port_decode u_decode (
        .wr_stb (wr_stb),
        .addr   (addr),
        .hit    (hit)
    );

    sysctl_key_matcher u_key (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (hit.key),
        .key_byte (wdata[7:0]),
        .fire     (shutdown_req)
    );

    sysctl_event_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .wdata       (wdata),
        .fpu_err_evt (fpu_err_evt),
        .a20_en      (a20_en),
        .fpu_irq     (fpu_irq),
        .fw_panic    (fw_panic),
        .vid_panic   (vid_panic),
        .panic_line  (panic_line),
        .char_vld    (char_vld),
        .char_data   (char_data)
    );

    always_comb begin
        rdata = '0;
        if (rd_stb && addr == P_A20) rdata[1] = a20_en;
    end
endmodule

// File: rtl/sysctl_port_checker.sv
module sysctl_port_checker
    import sysctl_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [15:0]       addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              fpu_err_evt,
    input logic              a20_en,
    input logic              fpu_irq,
    input logic              shutdown_req,
    input logic              fw_panic,
    input logic              char_vld
);
    AST_A20_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && addr == P_A20) |=> $stable(a20_en)); // R1
    AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && addr != P_A20) |-> (rdata == '0)); // R2
    AST_FPU_SET: assert property (@(posedge clk) disable iff (rst)
        fpu_err_evt |=> fpu_irq); // R4
    AST_FPU_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && addr == P_FPUCLR && !fpu_err_evt) |=> !fpu_irq); // R4
    AST_SHUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |=> !shutdown_req); // R7
    AST_SHUT_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(wr_stb && addr == P_KEY && wdata[7:0] == 8'h6E)); // R7
    AST_PANIC_SRC: assert property (@(posedge clk) disable iff (rst)
        fw_panic |-> $past(wr_stb && (addr == P_FWPAN0 || addr == P_FWPAN1))); // R8
    AST_CHAR_SRC: assert property (@(posedge clk) disable iff (rst)
        char_vld |-> $past(wr_stb)); // R10
endmodule

bind sysctl_port_decoder sysctl_port_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_stb       (wr_stb),
    .rd_stb       (rd_stb),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .fpu_err_evt  (fpu_err_evt),
    .a20_en       (a20_en),
    .fpu_irq      (fpu_irq),
    .shutdown_req (shutdown_req),
    .fw_panic     (fw_panic),
    .char_vld     (char_vld)
);

// File: tb/sysctl_port_decoder_bench.sv
module sysctl_port_decoder_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_stb, rd_stb, fpu_err_evt;
    logic [15:0] addr, wdata, rdata, panic_line;
    logic        a20_en, fpu_irq, shutdown_req, fw_panic, vid_panic, char_vld;
    logic [7:0]  char_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    sysctl_port_decoder u_sysctl_port_decoder (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
        .wdata(wdata), .rdata(rdata), .fpu_err_evt(fpu_err_evt),
        .a20_en(a20_en), .fpu_irq(fpu_irq), .shutdown_req(shutdown_req),
        .fw_panic(fw_panic), .vid_panic(vid_panic), .panic_line(panic_line),
        .char_vld(char_vld), .char_data(char_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write; returns at the negedge after the sampling edge
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0; addr = 16'h0; wdata = 16'h0;
    endtask

    task automatic send_key(input string s, input int fire_at);
        for (int i = 0; i < s.len(); i++) begin
            wr(16'h8900, {8'h00, s[i]});
            check("R6/R7 shutdown", {31'b0, shutdown_req}, {31'b0, (i == fire_at)});
        end
        @(negedge clk);
        check("R7 shutdown one cycle", {31'b0, shutdown_req}, 32'd0);
    endtask

    initial begin
        #(PERIOD*150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic a20_m, fpu_m;
        rst = 1'b1; wr_stb = 0; rd_stb = 0; fpu_err_evt = 0; addr = 0; wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check("R11 reset", {26'b0, a20_en, fpu_irq, shutdown_req, fw_panic, vid_panic, char_vld}, 32'd0);

        // R1: A20 set/clear, bit 0 ignored
        wr(16'h0092, 16'h0002); check("R1 a20 set", {31'b0, a20_en}, 32'd1);
        wr(16'h0092, 16'h0001); check("R1 a20 clear, bit0 ignored", {31'b0, a20_en}, 32'd0);
        check("R1 bit0 no reset effect", {29'b0, fw_panic, vid_panic, char_vld}, 32'd0);
        wr(16'h0092, 16'h0003); check("R1 a20 set with bit0", {31'b0, a20_en}, 32'd1);

        // R2: full read sweep with a20 high
        for (int a = 0; a < 65536; a++) begin
            @(negedge clk);
            rd_stb = 1'b1; addr = a[15:0];
            #1;
            check("R2 read", {16'b0, rdata}, (a == 32'h92) ? 32'd2 : 32'd0);
        end
        rd_stb = 1'b0;
        #1;
        check("R2 no strobe", {16'b0, rdata}, 32'd0);

        // R4/R5: FPU error latch, collision with clear
        @(negedge clk); fpu_err_evt = 1'b1;
        @(negedge clk); fpu_err_evt = 1'b0;
        check("R4 fpu set", {31'b0, fpu_irq}, 32'd1);
        repeat (3) @(negedge clk);
        check("R4 fpu held", {31'b0, fpu_irq}, 32'd1);
        @(negedge clk); fpu_err_evt = 1'b1; wr_stb = 1'b1; addr = 16'h00F0; wdata = 16'h1234;
        @(negedge clk); fpu_err_evt = 1'b0; wr_stb = 1'b0; addr = 0;
        check("R5 event beats clear", {31'b0, fpu_irq}, 32'd1);
        wr(16'h00F0, 16'hABCD); check("R4 fpu clear", {31'b0, fpu_irq}, 32'd0);

        // sweep writes over low port space against an arithmetic model
        @(negedge clk); fpu_err_evt = 1'b1;
        @(negedge clk); fpu_err_evt = 1'b0;
        a20_m = a20_en; fpu_m = 1'b1;
        for (int a = 0; a < 4096; a++) begin
            logic [15:0] d;
            logic ef, ev, ec;
            d  = a[15:0] ^ 16'h5A5A;
            ef = (a == 32'h400 || a == 32'h401);
            ev = (a == 32'h501 || a == 32'h502);
            ec = (a == 32'h402 || a == 32'h403 || a == 32'h500 || a == 32'h503);
            if (a == 32'h92) a20_m = d[1];
            if (a == 32'hF0) fpu_m = 1'b0;
            wr(a[15:0], d);
            check("R3/R1/R4 sweep levels", {30'b0, a20_en, fpu_irq}, {30'b0, a20_m, fpu_m});
            check("R3/R8/R9/R10 sweep strobes", {28'b0, fw_panic, vid_panic, char_vld, shutdown_req},
                  {28'b0, ef, ev, ec, 1'b0});
            if (ef) check("R8 panic value", {16'b0, panic_line}, {16'b0, d});
            if (ev) check("R9 panic value", {16'b0, panic_line}, {16'b0, d});
            if (ec) check("R10 char value", {24'b0, char_data}, {24'b0, d[7:0]});
        end

        // R8: one-cycle pulse and overwrite
        wr(16'h0400, 16'h0111);
        wr(16'h0401, 16'h0222);
        check("R8 overwrite", {16'b0, panic_line}, 32'h0222);
        @(negedge clk);
        check("R8 one cycle", {31'b0, fw_panic}, 32'd0);
        // R9 one cycle
        wr(16'h0502, 16'h0333);
        @(negedge clk);
        check("R9 one cycle", {31'b0, vid_panic}, 32'd0);
        // R3: post-code port leaves everything alone
        wr(16'h0080, 16'hFFFF);
        check("R3 post port", {16'b0, panic_line}, 32'h0333);
        check("R3 post strobes", {28'b0, fw_panic, vid_panic, char_vld, shutdown_req}, 32'd0);

        // R6/R7: key matching
        send_key("Shutdown", 7);
        send_key("Shutdown", 7);            // restart after fire
        send_key("ShutdowX", -1);
        send_key("SShutdown", -1);          // doubled S breaks the match
        send_key("Shut", -1);
        wr(16'h0080, 16'h0000);             // foreign port keeps the index
        wr(16'h0402, 16'h0041);
        send_key("down", 3);
        send_key("shutdown", -1);           // case matters

        // R11: reset mid-key and with levels set
        send_key("Shutdo", -1);
        wr(16'h0092, 16'h0002);
        @(negedge clk); fpu_err_evt = 1'b1;
        @(negedge clk); fpu_err_evt = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R11 reset levels", {30'b0, a20_en, fpu_irq}, 32'd0);
        send_key("wn", -1);
        send_key("Shutdown", 7);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule